// File: doc/BRIEF.md
# Shared-Memory Coefficient Loader

This block fills a filter device's coefficient store and its 16-bit control word from a byte-wide external memory. Several devices can share that one memory. A strap input picks the role. The master walks the memory: it drives the byte address, a 4-bit block number, a control/coefficient select bit and a write strobe. Every device on the bus watches these signals. Each device takes only the transfers tagged with its own block number. The master always owns block 0. A slave owns the block equal to its 4-bit code.

On the master, the same 4-bit code input gives the index of the last block to visit, which is also the number of slaves. Each block starts with two control transfers, made with the select bit high, at byte addresses 0 and 1. The coefficient bytes follow with the select bit low. Each 16-bit coefficient is built from two transfers, low byte first. The length setting fixes how many coefficient bytes each block holds, and that count already covers both coefficient banks. Loading starts by itself after reset and again whenever a reload is requested while the device is idle.

Top module: `coef_autoload`

## Requirements
- R1: While reset is held, `done`, `wr_en` and `coef_we` are 0. In the first cycle after reset is released, the master raises `wr_en` without any other request.
- R2: For each block in order 0, 1, ..., `dev_code`, the master makes two control transfers (`ctl_sel`=1, `mem_addr` 0 then 1) and then the coefficient transfers (`ctl_sel`=0, `mem_addr` from 0 upward). There is one transfer per cycle with `wr_en` held high throughout, for (`dev_code`+1)*(B+2) transfers in total.
- R3: B, the number of coefficient bytes per block, equals 2*(16 << `len_sel`). `mem_addr` never exceeds B-1 during coefficient transfers.
- R4: An accepted even-address coefficient byte is the low byte and the next odd-address byte is the high byte. One cycle after the odd transfer, `coef_we` pulses for a single cycle with `coef_idx` = address/2 and `coef_data` = {high, low}.
- R5: The accepted control bytes set `ctrl_word` to {byte at address 1, byte at address 0}.
- R6: A slave (`role`=1) accepts transfers only when `blk_in` equals `dev_code`. If its code is never visited, it writes nothing and `done` stays 0.
- R7: The master loads its own coefficients and control word from block 0 only.
- R8: The master's `done` rises in the cycle after the final transfer of the last block. A slave's `done` rises in the cycle after the final coefficient transfer of its own block.
- R9: A `reload` pulse while `done` is 1 clears `done` and restarts the full load. A `reload` while a load is running is ignored and does not shorten or restart it.
- R10: In slave mode `wr_en`, `ctl_sel`, `mem_addr` and `blk_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; load starts on release |
| role | input | 1 | 0 = master, 1 = slave |
| dev_code | input | 4 | Slave: own block number; master: last block index |
| len_sel | input | 2 | Filter length setting, B = 2*(16<<len_sel) |
| reload | input | 1 | Request a new load (honoured only when done) |
| mem_data | input | 8 | Byte read from the shared memory |
| addr_in | input | 8 | Slave: byte address seen on the bus |
| blk_in | input | 4 | Slave: block number seen on the bus |
| ctl_in | input | 1 | Slave: control select seen on the bus |
| wen_in | input | 1 | Slave: write strobe seen on the bus |
| mem_addr | output | 8 | Master: byte address |
| blk_out | output | 4 | Master: block number |
| ctl_sel | output | 1 | Master: high during control transfers |
| wr_en | output | 1 | Master: shared write strobe |
| ctrl_word | output | 16 | Loaded control word |
| coef_we | output | 1 | Coefficient write pulse |
| coef_idx | output | 7 | Coefficient index |
| coef_data | output | 16 | Assembled coefficient |
| done | output | 1 | Load complete |

## Verification
If the sequencer's address or block counter goes wrong, the bus pattern departs from the expected walk within one transfer. A wrong counter also changes the total length of the `wr_en` burst, so the end of the load moves by at least one cycle. If a byte lands in the wrong half of the coefficient register, or a device latches another block's data, the coefficient checksum and `ctrl_word` differ as soon as that block has finished. A selection error in the slave shows at the ports as writes appearing, missing or arriving at the wrong time relative to its block.

// File: rtl/coef_autoload.sv
module coef_autoload #(
  parameter int ADDR_W     = 8,
  parameter int CODE_W     = 4,
  parameter int LEN_W      = 2,
  parameter int BYTE_W     = 8,
  parameter int BASE_WORDS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                role,
  input  logic [CODE_W-1:0]   dev_code,
  input  logic [LEN_W-1:0]    len_sel,
  input  logic                reload,
  input  logic [BYTE_W-1:0]   mem_data,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic [CODE_W-1:0]   blk_in,
  input  logic                ctl_in,
  input  logic                wen_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [CODE_W-1:0]   blk_out,
  output logic                ctl_sel,
  output logic                wr_en,
  output logic [2*BYTE_W-1:0] ctrl_word,
  output logic                coef_we,
  output logic [ADDR_W-2:0]   coef_idx,
  output logic [2*BYTE_W-1:0] coef_data,
  output logic                done
);
  localparam int SPAN_W = ADDR_W + 1;

  logic              start_q, run_q, ctl_q, seq_done, own_done;
  logic [ADDR_W-1:0] lo_q;
  logic [CODE_W-1:0] blk_q;
  logic [BYTE_W-1:0] low_byte;
  logic [SPAN_W-1:0] span;
  logic [ADDR_W-1:0] last;

  wire master = ~role;
  wire start  = start_q | (reload & done);

  assign span = (SPAN_W'(2 * BASE_WORDS) << len_sel) - SPAN_W'(1);
  assign last = span[ADDR_W-1:0];

  wire [ADDR_W-1:0] b_addr = master ? lo_q  : addr_in;
  wire [CODE_W-1:0] b_blk  = master ? blk_q : blk_in;
  wire              b_ctl  = master ? ctl_q : ctl_in;
  wire              b_we   = master ? run_q : wen_in;
  wire [CODE_W-1:0] my_code = master ? '0 : dev_code;
  wire              hit     = b_we && (b_blk == my_code);

  assign mem_addr = lo_q;
  assign blk_out  = blk_q;
  assign ctl_sel  = ctl_q;
  assign wr_en    = run_q;
  assign done     = master ? seq_done : own_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b1;
      run_q    <= 1'b0;
      ctl_q    <= 1'b0;
      lo_q     <= '0;
      blk_q    <= '0;
      seq_done <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (start && master) begin
        run_q    <= 1'b1;
        ctl_q    <= 1'b1;
        lo_q     <= '0;
        blk_q    <= '0;
        seq_done <= 1'b0;
      end else if (run_q) begin
        if (ctl_q) begin
          if (lo_q[0]) begin
            ctl_q <= 1'b0;
            lo_q  <= '0;
          end else begin
            lo_q <= lo_q + 1'b1;
          end
        end else if (lo_q == last) begin
          lo_q <= '0;
          if (blk_q == dev_code) begin
            run_q    <= 1'b0;
            blk_q    <= '0;
            seq_done <= 1'b1;
          end else begin
            blk_q <= blk_q + 1'b1;
            ctl_q <= 1'b1;
          end
        end else begin
          lo_q <= lo_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_done  <= 1'b0;
      low_byte  <= '0;
      ctrl_word <= '0;
      coef_we   <= 1'b0;
      coef_idx  <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= 1'b0;
      if (start) own_done <= 1'b0;
      if (hit) begin
        if (b_ctl) begin
          if (b_addr[0]) ctrl_word[2*BYTE_W-1:BYTE_W] <= mem_data;
          else           ctrl_word[BYTE_W-1:0]        <= mem_data;
        end else begin
          if (!b_addr[0]) begin
            low_byte <= mem_data;
          end else begin
            coef_we   <= 1'b1;
            coef_idx  <= b_addr[ADDR_W-1:1];
            coef_data <= {mem_data, low_byte};
          end
          if (b_addr == last) own_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coef_autoload_chk.sv
module coef_autoload_chk #(
  parameter int ADDR_W     = 8,
  parameter int CODE_W     = 4,
  parameter int LEN_W      = 2,
  parameter int BASE_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              role,
  input logic [LEN_W-1:0]  len_sel,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CODE_W-1:0] blk_out,
  input logic              ctl_sel,
  input logic              wr_en,
  input logic              coef_we,
  input logic              done
);
  logic [ADDR_W:0] lim;
  assign lim = ((ADDR_W+1)'(2 * BASE_WORDS) << len_sel) - (ADDR_W+1)'(1);

  a_r10_slave_silent: assert property (@(posedge clk) disable iff (!rst_n)
    role |-> (!wr_en && !ctl_sel && mem_addr == '0 && blk_out == '0));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !role) |-> !wr_en);

  a_r2_ctl_two: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctl_sel) |-> (mem_addr < ADDR_W'(2)));

  a_r2_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_sel) && $past(wr_en)) |-> (blk_out == $past(blk_out) + 1'b1));

  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctl_sel) |-> ({1'b0, mem_addr} <= lim));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> !coef_we);
endmodule

bind coef_autoload coef_autoload_chk #(
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .LEN_W(LEN_W), .BASE_WORDS(BASE_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .role(role), .len_sel(len_sel),
  .mem_addr(mem_addr), .blk_out(blk_out), .ctl_sel(ctl_sel),
  .wr_en(wr_en), .coef_we(coef_we), .done(done)
);

// File: tb/test_coef_autoload.sv
module test_coef_autoload;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic [1:0] len_sel = '0;
  logic [3:0] m_code = '0, s_code = 4'd1;

  logic [7:0]  m_addr, s_addr, rom_q;
  logic [3:0]  m_blk, s_blk;
  logic        m_ctl, s_ctl, m_wen, s_wen, m_cwe, s_cwe, m_done, s_done;
  logic [15:0] m_ctrl, s_ctrl, m_cdata, s_cdata;
  logic [6:0]  m_cidx, s_cidx;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom(input logic [3:0] b, input logic c, input logic [7:0] a);
    logic [7:0] t;
    if (c) return {b, 3'b101, a[0]};
    t = a * 8'd37;
    return t + {b, 4'h3};
  endfunction

  function automatic logic [31:0] exp_sum(input logic [3:0] b, input int words);
    logic [31:0] s = 0;
    for (int w = 0; w < words; w++)
      s = s + (32'({rom(b, 1'b0, 8'(2*w+1)), rom(b, 1'b0, 8'(2*w))}) ^ 32'(w));
    return s;
  endfunction

  assign rom_q = rom(m_blk, m_ctl, m_addr);

  coef_autoload i_coef_autoload (
    .clk(clk), .rst_n(rst_n), .role(1'b0), .dev_code(m_code), .len_sel(len_sel),
    .reload(reload), .mem_data(rom_q), .addr_in(8'h00), .blk_in(4'h0),
    .ctl_in(1'b0), .wen_in(1'b0), .mem_addr(m_addr), .blk_out(m_blk),
    .ctl_sel(m_ctl), .wr_en(m_wen), .ctrl_word(m_ctrl), .coef_we(m_cwe),
    .coef_idx(m_cidx), .coef_data(m_cdata), .done(m_done));

  coef_autoload i_coef_autoload_s (
    .clk(clk), .rst_n(rst_n), .role(1'b1), .dev_code(s_code), .len_sel(len_sel),
    .reload(reload), .mem_data(rom_q), .addr_in(m_addr), .blk_in(m_blk),
    .ctl_in(m_ctl), .wen_in(m_wen), .mem_addr(s_addr), .blk_out(s_blk),
    .ctl_sel(s_ctl), .wr_en(s_wen), .ctrl_word(s_ctrl), .coef_we(s_cwe),
    .coef_idx(s_cidx), .coef_data(s_cdata), .done(s_done));

  // monitor
  logic clr_req = 1'b0;
  int cur_b = 32;
  int cyc = 1, xf, serr, maxa, mcnt, scnt, last_xf, m_done_at, s_last, s_done_at;
  logic [31:0] msum, ssum;
  logic [3:0] eb;
  logic ec;
  logic [7:0] ea;
  logic s_we_seen;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (clr_req) begin
      xf <= 0; serr <= 0; maxa <= 0; mcnt <= 0; scnt <= 0; msum <= 0; ssum <= 0;
      last_xf <= 0; m_done_at <= 0; s_last <= 0; s_done_at <= 0; s_we_seen <= 1'b0;
      eb <= 0; ec <= 1'b1; ea <= 0;
    end else begin
      if (m_wen) begin
        xf <= xf + 1;
        last_xf <= cyc;
        if (m_blk != eb || m_ctl != ec || m_addr != ea) serr <= serr + 1;
        if (ec) begin
          if (ea == 8'd1) begin ec <= 1'b0; ea <= 0; end else ea <= ea + 1'b1;
        end else if (int'(ea) == cur_b - 1) begin
          eb <= eb + 1'b1; ec <= 1'b1; ea <= 0;
        end else ea <= ea + 1'b1;
        if (!m_ctl && int'(m_addr) > maxa) maxa <= int'(m_addr);
        if (!m_ctl && m_blk == s_code && int'(m_addr) == cur_b - 1) s_last <= cyc;
      end
      if (m_done && m_done_at == 0) m_done_at <= cyc;
      if (s_done && s_done_at == 0) s_done_at <= cyc;
      if (m_cwe) begin mcnt <= mcnt + 1; msum <= msum + (32'(m_cdata) ^ 32'(m_cidx)); end
      if (s_cwe) begin scnt <= scnt + 1; ssum <= ssum + (32'(s_cdata) ^ 32'(s_cidx)); end
      if (s_wen) s_we_seen <= 1'b1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] len, input logic [3:0] n, input logic [3:0] s,
                         input bit use_reset, input bit mid_pulse);
    int words, total;
    len_sel = len; m_code = n; s_code = s;
    cur_b = 2 * (16 << len);
    words = cur_b / 2;
    total = (int'(n) + 1) * (cur_b + 2);
    @(negedge clk);
    if (use_reset) begin
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset state", {m_done, m_wen, m_cwe, s_done, s_cwe}, 5'b0);
      clr_req = 1'b1;
      @(negedge clk); #1;
      clr_req = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 self start", m_wen, 1'b1);
    end else begin
      clr_req = 1'b1;
      @(negedge clk); #1;
      clr_req = 1'b0;
      reload = 1'b1;
      @(negedge clk);
      reload = 1'b0;
      check("R9 done cleared on reload", m_done, 1'b0);
    end
    if (mid_pulse) begin
      repeat (10) @(negedge clk);
      reload = 1'b1;
      @(negedge clk);
      reload = 1'b0;
    end
    for (int i = 0; i < 6000 && !m_done; i++) @(negedge clk);
    @(negedge clk);
    check("R2 sequence order", serr, 0);
    check(mid_pulse ? "R9 busy reload ignored" : "R2 transfer count", xf, total);
    check("R3 top coef address", maxa, cur_b - 1);
    check("R8 master done timing", m_done_at, last_xf + 1);
    check("R4 master coef count", mcnt, words);
    check("R7 master block0 checksum", msum, exp_sum(4'd0, words));
    check("R5 master ctrl word", m_ctrl, {rom(4'd0, 1'b1, 8'd1), rom(4'd0, 1'b1, 8'd0)});
    check("R10 slave bus quiet", {s_we_seen, s_addr, s_blk, s_ctl}, 14'b0);
    if (s <= n) begin
      check("R6 slave coef count", scnt, words);
      check("R6 slave checksum", ssum, exp_sum(s, words));
      check("R5 slave ctrl word", s_ctrl, {rom(s, 1'b1, 8'd1), rom(s, 1'b1, 8'd0)});
      check("R8 slave done timing", s_done_at, s_last + 1);
    end else begin
      check("R6 unselected slave idle", {s_done, 32'(scnt)}, 33'b0);
    end
  endtask

  // {len[9:8], master code[7:4], slave code[3:0]}
  localparam logic [9:0] VEC [4] = '{
    {2'd0, 4'd1, 4'd1},
    {2'd1, 4'd3, 4'd2},
    {2'd2, 4'd2, 4'd2},
    {2'd3, 4'd0, 4'd5}
  };

  initial begin
    for (int v = 0; v < 4; v++)
      do_load(VEC[v][9:8], VEC[v][7:4], VEC[v][3:0], 1'b1, 1'b0);
    do_load(2'd1, 4'd2, 4'd2, 1'b1, 1'b0);
    do_load(2'd0, 4'd2, 4'd1, 1'b0, 1'b0);
    do_load(2'd0, 4'd3, 4'd3, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule